// File: doc/BRIEF.md
# Inter-core interrupt signalling unit

This block lets any core in a small cluster interrupt any other core, and lets the interrupted core find out which cores signalled it. All cores share one command port. A command carries an operation code, a core number, and the identity of the issuing core. The block keeps one sender mask per receiving core and drives one interrupt line per core. Each line stays high while its mask is non-empty.

When several cores signal the same target before it responds, their requests merge into one asserted line. The target reads its sender mask through the shared readback register. It then acknowledges each sender one at a time, and the line drops once the last sender has been acknowledged. A sender can poll a target's pending state before raising a new request, so that no request is lost.

Top module: `ipi_unit`

## Requirements
- R1: After reset every interrupt line is low and the readback register is zero.
- R2: Operation codes on `cmd_op`: 0 = status query, 1 = raise, 2 = source query, 3 = acknowledge. A command is taken in the cycle `cmd_valid` is high. A raise naming target T from requester S sets bit S of T's sender mask. `irq_out[T]` is high in the cycle after the command.
- R3: A status query naming target T loads the readback register with 1 if T's sender mask is non-empty, and with 0 otherwise. The value is visible in the cycle after the command.
- R4: A source query loads the readback register with the requester's own sender mask, where bit n set means core n signalled it. The value is visible in the cycle after the command.
- R5: Raises from several requesters to the same target before any acknowledge leave one asserted line. The source mask then has one bit set per requester.
- R6: An acknowledge naming core C clears only bit C of the requester's own sender mask. While other bits remain set, the requester's line stays high.
- R7: A core's line drops in the cycle after the acknowledge that clears the last bit of its mask.
- R8: A command whose core number or requester number is not below the core count changes no mask, no line and no readback bit.
- R9: A raise from a requester whose bit is already set in the target's mask leaves that mask unchanged.
- R10: Without a query command the readback register holds its value; raises and acknowledges do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Operation code (see R2) |
| cmd_core | input | $clog2(NCORES)+1 | Target core (raise, status) or sender core (acknowledge) |
| cmd_req | input | $clog2(NCORES)+1 | Number of the core issuing the command |
| readback | output | NCORES | Result of the last status or source query |
| irq_out | output | NCORES | Interrupt line per core |

## Verification
The hardest state to reach is a merged interrupt: several senders pending on one target, then partly acknowledged in an order that leaves some bits standing. The bench reaches it by a full sweep. For every target, it raises from each subset of senders, then acknowledges one sender at a time. After each step it compares the source mask, the status query and the line against a bench model. Out-of-range core and requester numbers are injected while a merged interrupt is pending, so that any stray write would show in the mask read back afterwards.

// File: rtl/ipi_unit.sv
module ipi_unit #(
  parameter int NCORES = 4,
  localparam int IDW = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int CW  = IDW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [CW-1:0]     cmd_core,
  input  logic [CW-1:0]     cmd_req,
  output logic [NCORES-1:0] readback,
  output logic [NCORES-1:0] irq_out
);
  localparam logic [1:0] OP_STAT  = 2'd0;
  localparam logic [1:0] OP_RAISE = 2'd1;
  localparam logic [1:0] OP_SRC   = 2'd2;
  localparam logic [1:0] OP_ACK   = 2'd3;
  localparam logic [CW-1:0] NC = CW'(NCORES);

  logic [NCORES-1:0] src_q [NCORES];

  wire            core_ok = cmd_core < NC;
  wire            req_ok  = cmd_req < NC;
  wire            go      = cmd_valid && core_ok && req_ok;
  wire [IDW-1:0]  core_ix = cmd_core[IDW-1:0];
  wire [IDW-1:0]  req_ix  = cmd_req[IDW-1:0];

  for (genvar t = 0; t < NCORES; t++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        src_q[t] <= '0;
      else if (go) begin
        if (cmd_op == OP_RAISE && core_ix == IDW'(t))
          src_q[t][req_ix] <= 1'b1;
        else if (cmd_op == OP_ACK && req_ix == IDW'(t))
          src_q[t][core_ix] <= 1'b0;
      end
    end
    assign irq_out[t] = |src_q[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      readback <= '0;
    else if (go) begin
      if (cmd_op == OP_STAT)
        readback <= NCORES'(irq_out[core_ix]);
      else if (cmd_op == OP_SRC)
        readback <= src_q[req_ix];
    end
  end
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
  parameter int NCORES = 4,
  localparam int IDW = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int CW  = IDW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [CW-1:0]     cmd_core,
  input logic [CW-1:0]     cmd_req,
  input logic [NCORES-1:0] readback,
  input logic [NCORES-1:0] irq_out
);
  localparam logic [CW-1:0] NC = CW'(NCORES);
  wire ok = (cmd_core < NC) && (cmd_req < NC);
  wire go = cmd_valid && ok;
  wire [IDW-1:0] core_ix = cmd_core[IDW-1:0];
  wire [IDW-1:0] req_ix  = cmd_req[IDW-1:0];

  // R3
  status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == 2'd0 |=> readback == NCORES'($past(irq_out[core_ix])));

  // R4
  source_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == 2'd2 |=> (readback != '0) == $past(irq_out[req_ix]));

  // R8
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !ok |=> $stable(irq_out) && $stable(readback));

  // R10
  readback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && (cmd_op == 2'd0 || cmd_op == 2'd2)) |=> $stable(readback));

  for (genvar t = 0; t < NCORES; t++) begin : g_core
    // R2
    raise_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && cmd_op == 2'd1 && core_ix == IDW'(t) |=> irq_out[t]);
    // R2
    rise_needs_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out[t]) |-> $past(go && cmd_op == 2'd1 && core_ix == IDW'(t)));
    // R7
    fall_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_out[t]) |-> $past(go && cmd_op == 2'd3 && req_ix == IDW'(t)));
  end
endmodule

bind ipi_unit ipi_unit_chk #(.NCORES(NCORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_core(cmd_core), .cmd_req(cmd_req), .readback(readback), .irq_out(irq_out)
);

// File: tb/ipi_unit_tb.sv
`timescale 1ns/1ps
module ipi_unit_tb;
  localparam int N  = 4;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [CW-1:0] cmd_core = '0;
  logic [CW-1:0] cmd_req = '0;
  logic [N-1:0] readback, irq_out;

  int n_run = 0, n_fail = 0;
  logic [N-1:0] model [N];
  logic [N-1:0] exp_irq;

  always #2.5 clk = ~clk;

  ipi_unit #(.NCORES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_core(cmd_core), .cmd_req(cmd_req), .readback(readback), .irq_out(irq_out)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(int op, int core, int req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_core = CW'(core); cmd_req = CW'(req);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [N-1:0] irq_model();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = |model[i];
    return r;
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", int'(irq_out), 0);
    check("R1 readback", int'(readback), 0);

    for (int t = 0; t < N; t++) begin
      for (int m = 1; m < (1 << N); m++) begin
        for (int s = 0; s < N; s++) if (m[s]) begin
          cmd(1, t, s);
          model[t][s] = 1'b1;
          check("R2 irq after raise", int'(irq_out), int'(irq_model()));
        end
        for (int s = 0; s < N; s++) if (m[s]) begin
          cmd(1, t, s);
          check("R9 duplicate raise keeps irq", int'(irq_out), int'(irq_model()));
          break;
        end
        cmd(2, 0, t);
        check("R4 R5 R9 source mask", int'(readback), m);
        cmd(0, t, (t + 1) % N);
        check("R3 status pending", int'(readback), 1);
        cmd(1, (t + 1) % N, t);
        check("R10 readback held over raise", int'(readback), 1);
        model[(t + 1) % N][t] = 1'b1;
        cmd(2, 0, (t + 1) % N);
        cmd(3, t, (t + 1) % N);
        model[(t + 1) % N][t] = 1'b0;
        check("R10 readback held over ack", int'(readback), 1 << t);
        if (m == (1 << N) - 1) begin
          cmd(1, N, 0);
          cmd(1, t, N + 1);
          cmd(3, 0, N + 2);
          cmd(3, N + 3, t);
          cmd(0, N, 0);
          check("R8 out-of-range readback", int'(readback), 1 << t);
          check("R8 out-of-range irq", int'(irq_out), int'(irq_model()));
          cmd(2, 0, t);
          check("R8 mask intact", int'(readback), m);
        end
        for (int s = 0; s < N; s++) if (m[s]) begin
          cmd(3, s, t);
          model[t][s] = 1'b0;
          exp_irq = irq_model();
          check("R6 R7 irq after ack", int'(irq_out), int'(exp_irq));
          cmd(2, 0, t);
          check("R6 remaining mask", int'(readback), int'(model[t]));
        end
        cmd(0, t, t);
        check("R3 status clear", int'(readback), 0);
        repeat (2) @(negedge clk);
        check("R10 idle hold", int'(readback), 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule